// File: doc/BRIEF.md
# Index/Data Configuration Window Redirector

This block sits between a host register request stream and a device's register aperture. Inside the aperture it watches a pair of 32-bit registers: an index register at aperture offset 0 and a data register at aperture offset 4, which together form an 8-byte window. A host write to the index register can arm the block. It does so when the written word, with its low offset bits cleared, equals a fixed match value. The low bits of that word are then latched as a configuration-space offset. While the block is armed, accesses that touch the data register go to a separate configuration-space port instead of the device. All other accesses, including every index access, go through to the device aperture. There they land at the host address plus a fixed base offset.

Routing is combinational, so a request costs no extra cycle. The host request is a valid/ready stream. When the host raises `h_valid`, it must hold the request fields stable until it sees `h_ready` high at a rising clock edge. `h_ready` is the ready of whichever downstream port the request is steered to, so back-pressure from that port reaches the host directly. Read data on `h_rdata` is valid in the handshake cycle and comes from the port that accepts the request.

A sticky error flag records malformed window accesses, and a separate clear input resets it. The access that raised the error is still issued in the normal way.

Top module: `cfg_window_redirect`

## Requirements
- R1: After reset the block is disarmed, the latched offset is 0 and `err_flag` is 0, so every access goes to the device port.
- R2: A handshaken write that overlaps aperture bytes 0..3 (the index register) compares the whole 32-bit `h_wdata`, with bits 11:0 cleared, against 0x4000. On equality the block becomes armed and latches `h_wdata[11:0]` as the offset, taking effect from the next request.
- R3: An index-overlapping write whose word does not match (for example 0x3FFF, 0x5000 or 0x14000) disarms the block.
- R4: While the block is armed, a read or write that overlaps aperture bytes 4..7 is steered to the config port. Its `c_addr` is (offset + h_addr − 4) modulo 4096, and it carries the host's write flag, size and write data unchanged.
- R5: Every other access, including all index accesses and all data accesses while disarmed, is forwarded to the device port at `d_addr` = `h_addr` + 0x100 (16 bits), with write flag, size and write data unchanged. Index writes are forwarded as well as latched.
- R6: Exactly the chosen downstream port sees valid and the other port's valid stays low. `h_ready` equals the chosen port's ready, and `h_rdata` equals the chosen port's read data.
- R7: A handshaken access that overlaps the data register but does not lie wholly within bytes 4..7 sets `err_flag`.
- R8: A handshaken write that overlaps the index register but does not start at offset 0 sets `err_flag` and still updates the index state. Reads of the index register never raise an error.
- R9: `err_flag` stays set until `err_clear` is high at a clock edge. If an error and a clear occur at the same edge, the flag ends up set.
- R10: `h_size` encodes the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, and 3 is treated as 4 bytes for all decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Host request accepted (chosen port's ready) |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | 8 | Byte address within the aperture |
| h_size | input | 2 | Access width code (R10) |
| h_wdata | input | 32 | Write data, little-endian, low-aligned |
| h_rdata | output | 32 | Read data of the accepted request |
| d_valid | output | 1 | Device request valid |
| d_ready | input | 1 | Device ready |
| d_write | output | 1 | Device write flag |
| d_addr | output | 16 | Device address (host address plus base) |
| d_size | output | 2 | Device access width code |
| d_wdata | output | 32 | Device write data |
| d_rdata | input | 32 | Device read data |
| c_valid | output | 1 | Config request valid |
| c_ready | input | 1 | Config ready |
| c_write | output | 1 | Config write flag |
| c_addr | output | 12 | Config-space byte address |
| c_size | output | 2 | Config access width code |
| c_wdata | output | 32 | Config write data |
| c_rdata | input | 32 | Config read data |
| err_clear | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky window-misuse error |

## Verification
The armed bit and the offset cannot be read out directly, so a corrupted value can only be seen on the next data-register access. That access shows up on the wrong port, or on the config port at a wrong `c_addr`, in the same cycle it is presented. For this reason the bench follows every index write with data-register reads across all widths and byte offsets, including offsets that wrap past the top of the 4 KiB config space. A wrong error state shows on `err_flag` one edge after the handshake that should or should not have set it.

// File: rtl/cwr_pkg.sv
package cwr_pkg;

  // Access width codes carried on the size fields.
  localparam logic [1:0] SZ_1B = 2'd0;
  localparam logic [1:0] SZ_2B = 2'd1;

  // Byte count of an access; the reserved code counts as a full word.
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_1B:   size_bytes = 3'd1;
      SZ_2B:   size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/cwr_span_check.sv
module cwr_span_check
  import cwr_pkg::*;
#(
  parameter int AW          = 8,
  parameter int BASE        = 0,
  parameter int LEN         = 4,
  parameter bit STRICT_BASE = 1'b0
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output logic          overlap,
  output logic          misfit
);

  localparam int EW = AW + 2;
  localparam logic [EW-1:0] LO_B = EW'(BASE);
  localparam logic [EW-1:0] HI_B = EW'(BASE + LEN);

  logic [EW-1:0] lo;
  logic [EW-1:0] hi;
  logic [EW-1:0] rel;
  logic [EW:0]   end_rel;
  logic          contained;

  always_comb begin
    lo        = EW'(addr);
    hi        = lo + EW'(size_bytes(size));
    rel       = lo - LO_B;
    // One extra bit so an access starting below BASE cannot wrap into range.
    end_rel   = {1'b0, rel} + (EW+1)'(size_bytes(size));
    overlap   = (lo < HI_B) && (LO_B < hi);
    contained = (end_rel <= (EW+1)'(LEN));
  end

  generate
    if (STRICT_BASE) begin : g_strict
      logic at_base;
      assign at_base = (lo == LO_B);
      assign misfit  = overlap && (!contained || !at_base);
    end else begin : g_loose
      assign misfit  = overlap && !contained;
    end
  endgenerate

endmodule

// File: rtl/cwr_index_reg.sv
module cwr_index_reg #(
  parameter int              DW    = 32,
  parameter int              CW    = 12,
  parameter logic [DW-1:0]   MATCH = 32'h0000_4000,
  parameter logic [DW-1:0]   MASK  = 32'h0000_0FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [DW-1:0] wdata,
  output logic          armed,
  output logic [CW-1:0] offset
);

  localparam logic [CW-1:0] OFS_MASK = MASK[CW-1:0];

  logic          hit;
  logic [CW-1:0] ofs_next;

  assign hit      = ((wdata & ~MASK) == MATCH);
  assign ofs_next = wdata[CW-1:0] & OFS_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      offset <= '0;
    end else if (upd) begin
      armed <= hit;
      if (hit) offset <= ofs_next;
    end
  end

  p_arm_on_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && ((wdata & ~MASK) == MATCH)) |=>
      (armed && offset == ($past(wdata[CW-1:0]) & OFS_MASK)));

  p_disarm_on_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && ((wdata & ~MASK) != MATCH)) |=> !armed);

  p_hold_without_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(armed) && $stable(offset)));

endmodule

// File: rtl/cwr_sticky_err.sv
module cwr_sticky_err (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);

endmodule

// File: rtl/cfg_window_redirect.sv
module cfg_window_redirect #(
  parameter int            AW       = 8,
  parameter int            DW       = 32,
  parameter int            CW       = 12,
  parameter int            DEV_AW   = 16,
  parameter int            IDX_OFS  = 0,
  parameter int            DAT_OFS  = 4,
  parameter int            REG_LEN  = 4,
  parameter int            BASE_OFS = 'h100,
  parameter logic [DW-1:0] MATCH    = 32'h0000_4000,
  parameter logic [DW-1:0] MASK     = 32'h0000_0FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_write,
  input  logic [AW-1:0]     h_addr,
  input  logic [1:0]        h_size,
  input  logic [DW-1:0]     h_wdata,
  output logic [DW-1:0]     h_rdata,
  output logic              d_valid,
  input  logic              d_ready,
  output logic              d_write,
  output logic [DEV_AW-1:0] d_addr,
  output logic [1:0]        d_size,
  output logic [DW-1:0]     d_wdata,
  input  logic [DW-1:0]     d_rdata,
  output logic              c_valid,
  input  logic              c_ready,
  output logic              c_write,
  output logic [CW-1:0]     c_addr,
  output logic [1:0]        c_size,
  output logic [DW-1:0]     c_wdata,
  input  logic [DW-1:0]     c_rdata,
  input  logic              err_clear,
  output logic              err_flag
);

  localparam int NREG = 2;
  localparam int REG_BASE [NREG] = '{IDX_OFS, DAT_OFS};

  logic [NREG-1:0] ov;
  logic [NREG-1:0] bad;

  // Slot 0 decodes the index register (must start at its base), slot 1 the data register.
  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_span
      cwr_span_check #(
        .AW         (AW),
        .BASE       (REG_BASE[gi]),
        .LEN        (REG_LEN),
        .STRICT_BASE(gi == 0)
      ) u_span (
        .addr   (h_addr),
        .size   (h_size),
        .overlap(ov[gi]),
        .misfit (bad[gi])
      );
    end
  endgenerate

  logic          hs;
  logic          redirect;
  logic          armed;
  logic [CW-1:0] offset;
  logic          idx_upd;
  logic          err_set;

  assign redirect = armed && ov[1];
  assign h_ready  = redirect ? c_ready : d_ready;
  assign hs       = h_valid && h_ready;
  assign idx_upd  = hs && h_write && ov[0];
  assign err_set  = hs && (bad[1] || (h_write && bad[0]));

  cwr_index_reg #(
    .DW   (DW),
    .CW   (CW),
    .MATCH(MATCH),
    .MASK (MASK)
  ) u_index (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (idx_upd),
    .wdata (h_wdata),
    .armed (armed),
    .offset(offset)
  );

  cwr_sticky_err u_err (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (err_set),
    .clr  (err_clear),
    .flag (err_flag)
  );

  // Request steering; payload is broadcast, only valid is qualified.
  assign d_valid = h_valid && !redirect;
  assign c_valid = h_valid && redirect;
  assign d_write = h_write;
  assign c_write = h_write;
  assign d_size  = h_size;
  assign c_size  = h_size;
  assign d_wdata = h_wdata;
  assign c_wdata = h_wdata;
  assign d_addr  = DEV_AW'(h_addr) + DEV_AW'(BASE_OFS);
  assign c_addr  = offset + CW'(h_addr) - CW'(DAT_OFS);
  assign h_rdata = redirect ? c_rdata : d_rdata;

  p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid |-> $onehot({d_valid, c_valid}));

  p_bad_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_ready && bad[1]) |=> err_flag);

  p_idx_read_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_ready && !h_write && !bad[1] && !err_flag && !err_clear) |=> !err_flag);

endmodule

// File: tb/cfg_window_redirect_test.sv
module cfg_window_redirect_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_valid = 1'b0;
  logic        h_ready;
  logic        h_write = 1'b0;
  logic [7:0]  h_addr = '0;
  logic [1:0]  h_size = '0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        d_valid, d_write, c_valid, c_write;
  logic        d_ready = 1'b1, c_ready = 1'b1;
  logic [15:0] d_addr;
  logic [11:0] c_addr;
  logic [1:0]  d_size, c_size;
  logic [31:0] d_wdata, c_wdata, d_rdata, c_rdata;
  logic        err_clear = 1'b0;
  logic        err_flag;

  // Responders return a value derived from the address they see.
  assign d_rdata = {16'hD0D0, d_addr};
  assign c_rdata = {20'hC0C0C, c_addr};

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_window_redirect uut (
    .clk(clk), .rst_n(rst_n),
    .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write), .h_addr(h_addr),
    .h_size(h_size), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .d_valid(d_valid), .d_ready(d_ready), .d_write(d_write), .d_addr(d_addr),
    .d_size(d_size), .d_wdata(d_wdata), .d_rdata(d_rdata),
    .c_valid(c_valid), .c_ready(c_ready), .c_write(c_write), .c_addr(c_addr),
    .c_size(c_size), .c_wdata(c_wdata), .c_rdata(c_rdata),
    .err_clear(err_clear), .err_flag(err_flag)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state kept from the requirements.
  bit          m_armed = 0;
  logic [11:0] m_ofs = '0;
  bit          m_err = 0;
  bit          clr_during = 0;
  int          nacc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int addr, input int sz,
                        input logic [31:0] wd, input bit stall);
    int nb = (sz >= 2) ? 4 : sz + 1;
    bit idx_ov  = (addr < 4);
    bit dat_ov  = (addr < 8) && (addr + nb > 4);
    bit dat_in  = (addr >= 4) && (addr + nb <= 8);
    bit redir   = m_armed && dat_ov;
    bit e_dat   = dat_ov && !dat_in;
    bit e_idx   = wr && idx_ov && (addr != 0);
    logic [31:0] exp_ca = 32'((int'(m_ofs) + addr - 4) & 'hFFF);
    logic [31:0] exp_da = 32'((addr + 'h100) & 'hFFFF);
    string rq   = redir ? "R4" : "R5";
    @(negedge clk);
    h_valid = 1; h_write = wr; h_addr = 8'(addr); h_size = 2'(sz); h_wdata = wd;
    d_ready = !stall; c_ready = !stall; err_clear = clr_during;
    #1;
    chk(c_valid == redir && d_valid == !redir, "R6", "port select",
        {30'd0, c_valid, d_valid}, {30'd0, redir, !redir});
    chk(h_ready == !stall, "R6", "ready follows port", 32'(h_ready), 32'(!stall));
    if (redir) begin
      chk(32'(c_addr) == exp_ca, rq, "config address", 32'(c_addr), exp_ca);
      chk(c_write == wr && c_size == 2'(sz) && c_wdata == wd, rq, "config payload",
          c_wdata, wd);
      chk(h_rdata == {20'hC0C0C, exp_ca[11:0]}, "R6", "read data from config",
          h_rdata, {20'hC0C0C, exp_ca[11:0]});
    end else begin
      chk(32'(d_addr) == exp_da, rq, "device address", 32'(d_addr), exp_da);
      chk(d_write == wr && d_size == 2'(sz) && d_wdata == wd, rq, "device payload",
          d_wdata, wd);
      chk(h_rdata == {16'hD0D0, exp_da[15:0]}, "R6", "read data from device",
          h_rdata, {16'hD0D0, exp_da[15:0]});
    end
    if (stall) begin
      @(negedge clk);
      d_ready = 1; c_ready = 1;
      #1;
      chk(h_ready == 1'b1, "R6", "ready after stall", 32'(h_ready), 32'd1);
    end
    @(posedge clk);
    #1;
    h_valid = 0; err_clear = 0;
    if (wr && idx_ov) begin
      if ((wd & ~32'hFFF) == 32'h4000) begin m_armed = 1; m_ofs = wd[11:0]; end
      else m_armed = 0;
    end
    if (e_dat || e_idx) m_err = 1;
    else if (clr_during) m_err = 0;
    @(negedge clk);
    chk(err_flag == m_err, e_dat ? "R7" : (e_idx ? "R8" : "R9"), "error flag",
        32'(err_flag), 32'(m_err));
  endtask

  task automatic pulse_clear();
    @(negedge clk); err_clear = 1;
    @(negedge clk); err_clear = 0; m_err = 0;
    chk(err_flag == 1'b0, "R9", "flag cleared", 32'(err_flag), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(err_flag == 1'b0, "R1", "error after reset", 32'(err_flag), 32'd0);
    rst_n = 1;
    // R1: disarmed after reset, data read goes to the device.
    access(0, 4, 2, 32'h0, 0);

    // R5, R7, R8, R10: disarmed sweep, nothing matches.
    for (int wr = 0; wr < 2; wr++)
      for (int a = 0; a < 12; a++)
        for (int s = 0; s < 4; s++) begin
          access(wr[0], a, s, 32'h1234_5000 + 32'(a), (nacc % 3) == 0);
          nacc++;
        end
    pulse_clear();

    // R2, R4, R3: armed sweep, re-arming before each access with a fresh offset.
    for (int wr = 0; wr < 2; wr++)
      for (int a = 0; a < 12; a++)
        for (int s = 0; s < 4; s++) begin
          access(1, 0, 2, 32'h4000 | 32'(((a * 4 + s) * 'h155) & 'hFFF), 0);
          access(wr[0], a, s, 32'hA500_0000 + 32'(a), (nacc % 4) == 1);
          nacc++;
        end
    pulse_clear();

    // R2/R3 match boundaries, each probed with a full and a wrapping byte read.
    access(1, 0, 2, 32'h0000_4FFF, 0);
    access(0, 4, 2, 32'h0, 0);
    access(0, 7, 0, 32'h0, 0);          // R4 wraps offset 0xFFF + 3
    access(1, 0, 2, 32'h0000_3FFF, 0);  // R3
    access(0, 4, 2, 32'h0, 0);
    access(1, 0, 2, 32'h0000_4000, 0);
    access(0, 6, 1, 32'h0, 0);
    access(1, 0, 2, 32'h0000_5000, 0);  // R3
    access(0, 5, 0, 32'h0, 0);
    access(1, 0, 2, 32'h0000_4123, 0);
    access(1, 0, 2, 32'h0001_4000, 0);  // R3 high bit differs
    access(0, 4, 3, 32'h0, 0);          // R10 reserved code as a word
    // R2 with a byte-wide index write; R8 index read leaves state and flag alone.
    access(1, 0, 0, 32'h0000_4010, 0);
    access(0, 0, 2, 32'h0, 0);
    access(0, 4, 2, 32'h0, 0);

    // R9: error and clear on the same edge keeps the flag set, then clear.
    clr_during = 1;
    access(0, 6, 2, 32'h0, 0);
    access(0, 4, 2, 32'h0, 0);
    clr_during = 0;
    pulse_clear();
    access(1, 2, 1, 32'h0000_4044, 1);  // R8 misaligned index write still arms
    access(0, 4, 0, 32'h0, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule